// File: doc/BRIEF.md
# Half-line raster timing generator

This block produces the horizontal and vertical timing for a raster display from one master pixel clock. A programmable prescaler (divide by 1, 2 or 4) paces a horizontal position counter. Each scan line is made of two half lines of equal length, and every horizontal compare point names the half line it belongs to. The vertical counter steps once per half line. A frame therefore may begin in the middle of a scan line, and an odd half-line total gives interlaced fields that start on alternating half-line phases.

All timing values arrive on plain configuration inputs. The block samples them into a shadow set once after reset and again at every frame wrap. A change made in the middle of a frame only takes effect from the next frame. The outputs are registered. Sync pins have selectable polarity. In line-doubling mode a repeat flag marks every second display line, so that a fetch unit downstream can reuse the previous line. No data stream crosses this block, so it has no valid/ready handshake. Every port is a plain level.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is asserted, `hsync` and `vsync` are 1 (inactive, active-low), and `hblank`, `vblank`, `disp_en`, `field` and `line_repeat` are 0.
- R2: The horizontal position advances once every P master clocks. P is 1 for `cfg_presc` = 0, 2 for 1, and 4 for 2 or 3.
- R3: A half line is `cfg_h_total`+2 positions long, and a line is two half lines. Horizontal compare inputs of 10 bits hold an offset in bits 8:0. When bit 9 is 0 the point lies in the first half line, at line position equal to the offset. When bit 9 is 1 it lies in the second half line, at `cfg_h_total`+2 plus the offset. Horizontal display runs from the `cfg_h_disp_on` point up to, but not including, line position `cfg_h_total`+2+`cfg_h_disp_off`.
- R4: `hblank` is 1 at every line position except the range from the `cfg_h_blank_off` point (inclusive) to the `cfg_h_blank_on` point (exclusive). Horizontal sync is active from the `cfg_h_sync_on` point to the end of the line. With `cfg_h_sync_on` at or after `cfg_h_blank_on`, sync lies inside blanking.
- R5: The vertical counter counts half lines from 0 to `cfg_v_total` and then wraps. Vertical display covers counts from `cfg_v_disp_on` up to, but not including, `cfg_v_disp_off`. `vblank` is 1 except for counts from `cfg_v_blank_off` up to, but not including, `cfg_v_blank_on`. Vertical sync is active from `cfg_v_sync_on` through `cfg_v_total`.
- R6: `disp_en` is 1 exactly when both horizontal display and vertical display are active.
- R7: `cfg_h_pol`=1 or `cfg_v_pol`=1 makes the matching sync pin active-high. A value of 0 makes it active-low.
- R8: At each frame wrap `field` toggles when interlace is selected for the new frame, and is forced to 0 otherwise. With an odd half-line total, successive frames start on alternating half-line phases.
- R9: `line_repeat` is 1 during vertical display when line doubling is on, interlace is off, and bit 1 of (count − `cfg_v_disp_on`) is 1. When interlace is also selected, interlace takes precedence and `line_repeat` stays 0.
- R10: Configuration is captured on the first clock after reset and at each frame wrap. Outputs lag the counter state by one clock, so the first output state of a frame appears two clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_h_total | input | 9 | Half-line length minus 2, in prescaled units |
| cfg_h_disp_on | input | 10 | Horizontal display start point (bit 9 = half select) |
| cfg_h_disp_off | input | 9 | Horizontal display end offset within the second half |
| cfg_h_blank_on | input | 10 | Horizontal blank start point |
| cfg_h_blank_off | input | 10 | Horizontal blank end point |
| cfg_h_sync_on | input | 10 | Horizontal sync start point |
| cfg_v_total | input | 11 | Last half-line count of a frame |
| cfg_v_blank_on | input | 11 | Vertical blank start count |
| cfg_v_blank_off | input | 11 | Vertical blank end count |
| cfg_v_disp_on | input | 11 | Vertical display start count |
| cfg_v_disp_off | input | 11 | Vertical display end count |
| cfg_v_sync_on | input | 11 | Vertical sync start count |
| cfg_h_pol | input | 1 | Horizontal sync active-high when 1 |
| cfg_v_pol | input | 1 | Vertical sync active-high when 1 |
| cfg_presc | input | 2 | Prescale select |
| cfg_interlace | input | 1 | Interlace mode |
| cfg_double | input | 1 | Line-doubling mode |
| hsync | output | 1 | Horizontal sync pin |
| vsync | output | 1 | Vertical sync pin |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| disp_en | output | 1 | Display enable |
| field | output | 1 | Interlace field flag |
| line_repeat | output | 1 | Doubled-line repeat marker |

## Verification
Some rules are checked by assertions on every cycle. The prescale counter and the horizontal position stay inside their bounds, and the position holds between prescale ticks. The half-line counter steps by one or wraps at its total. The field flag stays 0 when interlace is off. Sync is active only inside blanking when the sync point follows the blank point. The repeat flag never appears unless doubling is on without interlace.

Other behaviour can only be shown by the bench scenarios, which compare every output on every clock against an independently built frame sequence. Those scenarios cover the exact placement of each window edge in either half line, the polarity of the sync pins, field alternation across odd-length frames, the repeat pattern, and the rule that a mid-frame change waits for the frame wrap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int HW  = 9;        // horizontal register width
  localparam int VW  = 11;       // vertical register width
  localparam int PSW = 2;        // prescale select width
  localparam int PCW = 2;        // prescale counter width (max divide 4)
  localparam int LPW = HW + 2;   // full-line position width

  typedef struct packed {
    logic [HW-1:0] h_total;
    logic [HW:0]   h_disp_on;
    logic [HW-1:0] h_disp_off;
    logic [HW:0]   h_blank_on;
    logic [HW:0]   h_blank_off;
    logic [HW:0]   h_sync_on;
    logic [VW-1:0] v_total;
    logic [VW-1:0] v_blank_on;
    logic [VW-1:0] v_blank_off;
    logic [VW-1:0] v_disp_on;
    logic [VW-1:0] v_disp_off;
    logic [VW-1:0] v_sync_on;
    logic          h_pol;
    logic          v_pol;
    logic [PSW-1:0] presc;
    logic          ilace;
    logic          dbl;
  } rtg_cfg_t;

  // last prescale count for a select value: divide 1, 2, or 4
  function automatic logic [PCW-1:0] presc_last(input logic [PSW-1:0] sel);
    if (sel == PSW'(0))      return PCW'(0);
    else if (sel == PSW'(1)) return PCW'(1);
    else                     return PCW'(3);
  endfunction
endpackage

// File: rtl/rtg_hcount.sv
module rtg_hcount
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [PSW-1:0] presc,
  input  logic [HW-1:0]  h_total,
  output logic [PCW-1:0] pc,
  output logic [HW:0]    hpos,
  output logic           hhalf,
  output logic           half_end
);
  logic [HW:0]    hlast;
  logic [PCW-1:0] plast;
  logic           tick;

  assign hlast    = {1'b0, h_total} + (HW+1)'(1);
  assign plast    = presc_last(presc);
  assign tick     = run && (pc == plast);
  assign half_end = tick && (hpos == hlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      hpos  <= '0;
      hhalf <= 1'b0;
    end else if (run) begin
      pc <= tick ? '0 : pc + PCW'(1);
      if (tick) begin
        if (hpos == hlast) begin
          hpos  <= '0;
          hhalf <= ~hhalf;
        end else begin
          hpos <= hpos + (HW+1)'(1);
        end
      end
    end
  end

  assert_pc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= plast);
  assert_pace_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(hpos));
  assert_hpos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hpos <= hlast);
endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          half_end,
  input  logic [VW-1:0] v_total,
  input  logic          ilace_next,
  output logic [VW-1:0] vcnt,
  output logic          field_st,
  output logic          frame_wrap
);
  assign frame_wrap = half_end && (vcnt == v_total);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt     <= '0;
      field_st <= 1'b0;
    end else if (half_end) begin
      if (frame_wrap) begin
        vcnt     <= '0;
        field_st <= ilace_next ? ~field_st : 1'b0;
      end else begin
        vcnt <= vcnt + VW'(1);
      end
    end
  end

  assert_vcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= v_total);
  assert_vstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !frame_wrap) |=> (vcnt == $past(vcnt) + VW'(1)));
  assert_vhold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !half_end |=> $stable(vcnt));
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode
  import rtg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] h_total,
  input  logic [HW:0]   h_disp_on,
  input  logic [HW-1:0] h_disp_off,
  input  logic [HW:0]   h_blank_on,
  input  logic [HW:0]   h_blank_off,
  input  logic [HW:0]   h_sync_on,
  input  logic [VW-1:0] v_blank_on,
  input  logic [VW-1:0] v_blank_off,
  input  logic [VW-1:0] v_disp_on,
  input  logic [VW-1:0] v_disp_off,
  input  logic [VW-1:0] v_sync_on,
  input  logic          h_pol,
  input  logic          v_pol,
  input  logic          ilace,
  input  logic          dbl,
  input  logic [HW:0]   hpos,
  input  logic          hhalf,
  input  logic [VW-1:0] vcnt,
  input  logic          field_st,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          disp_en,
  output logic          field,
  output logic          line_repeat
);
  logic [LPW-1:0] hn, cur, p_don, p_doff, p_bon, p_boff, p_son;
  logic           h_de, h_bl, h_sy, v_de, v_bl, v_sy, rep;
  logic [VW-1:0]  vrel;
  logic           hs_act_q, vs_act_q, hpol_q, vpol_q;

  // map a {half, offset} compare value onto the full-line position axis
  function automatic logic [LPW-1:0] to_line(input logic [HW:0] pt, input logic [LPW-1:0] n);
    return pt[HW] ? n + LPW'(pt[HW-1:0]) : LPW'(pt[HW-1:0]);
  endfunction

  assign hn     = LPW'(h_total) + LPW'(2);
  assign cur    = hhalf ? hn + LPW'(hpos) : LPW'(hpos);
  assign p_don  = to_line(h_disp_on, hn);
  assign p_doff = hn + LPW'(h_disp_off);
  assign p_bon  = to_line(h_blank_on, hn);
  assign p_boff = to_line(h_blank_off, hn);
  assign p_son  = to_line(h_sync_on, hn);

  assign h_de = (cur >= p_don) && (cur < p_doff);
  assign h_bl = !((cur >= p_boff) && (cur < p_bon));
  assign h_sy = (cur >= p_son);

  assign v_de = (vcnt >= v_disp_on) && (vcnt < v_disp_off);
  assign v_bl = !((vcnt >= v_blank_off) && (vcnt < v_blank_on));
  assign v_sy = (vcnt >= v_sync_on);

  assign vrel = vcnt - v_disp_on;
  assign rep  = dbl && !ilace && v_de && vrel[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_act_q    <= 1'b0;
      vs_act_q    <= 1'b0;
      hpol_q      <= 1'b0;
      vpol_q      <= 1'b0;
      hblank      <= 1'b0;
      vblank      <= 1'b0;
      disp_en     <= 1'b0;
      field       <= 1'b0;
      line_repeat <= 1'b0;
    end else if (run) begin
      hs_act_q    <= h_sy;
      vs_act_q    <= v_sy;
      hpol_q      <= h_pol;
      vpol_q      <= v_pol;
      hblank      <= h_bl;
      vblank      <= v_bl;
      disp_en     <= h_de && v_de;
      field       <= field_st;
      line_repeat <= rep;
    end
  end

  assign hsync = hpol_q ? hs_act_q : ~hs_act_q;
  assign vsync = vpol_q ? vs_act_q : ~vs_act_q;

  assert_sync_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_act_q && $past(run && (p_son >= p_bon))) |-> hblank);
  assert_rep_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    line_repeat |-> $past(dbl && !ilace));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  cfg_h_total,
  input  logic [HW:0]    cfg_h_disp_on,
  input  logic [HW-1:0]  cfg_h_disp_off,
  input  logic [HW:0]    cfg_h_blank_on,
  input  logic [HW:0]    cfg_h_blank_off,
  input  logic [HW:0]    cfg_h_sync_on,
  input  logic [VW-1:0]  cfg_v_total,
  input  logic [VW-1:0]  cfg_v_blank_on,
  input  logic [VW-1:0]  cfg_v_blank_off,
  input  logic [VW-1:0]  cfg_v_disp_on,
  input  logic [VW-1:0]  cfg_v_disp_off,
  input  logic [VW-1:0]  cfg_v_sync_on,
  input  logic           cfg_h_pol,
  input  logic           cfg_v_pol,
  input  logic [PSW-1:0] cfg_presc,
  input  logic           cfg_interlace,
  input  logic           cfg_double,
  output logic           hsync,
  output logic           vsync,
  output logic           hblank,
  output logic           vblank,
  output logic           disp_en,
  output logic           field,
  output logic           line_repeat
);
  rtg_cfg_t       cfg_in, sh;
  logic           init_q;
  logic [PCW-1:0] pc;
  logic [HW:0]    hpos;
  logic           hhalf, half_end, frame_wrap, field_st;
  logic [VW-1:0]  vcnt;

  assign cfg_in = '{h_total: cfg_h_total, h_disp_on: cfg_h_disp_on,
                    h_disp_off: cfg_h_disp_off, h_blank_on: cfg_h_blank_on,
                    h_blank_off: cfg_h_blank_off, h_sync_on: cfg_h_sync_on,
                    v_total: cfg_v_total, v_blank_on: cfg_v_blank_on,
                    v_blank_off: cfg_v_blank_off, v_disp_on: cfg_v_disp_on,
                    v_disp_off: cfg_v_disp_off, v_sync_on: cfg_v_sync_on,
                    h_pol: cfg_h_pol, v_pol: cfg_v_pol, presc: cfg_presc,
                    ilace: cfg_interlace, dbl: cfg_double};

  // shadow set: loaded once after reset, then only at the frame wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      sh     <= '0;
    end else begin
      init_q <= 1'b0;
      if (init_q || frame_wrap) sh <= cfg_in;
    end
  end

  rtg_hcount u_hcount (
    .clk(clk), .rst_n(rst_n), .run(!init_q), .presc(sh.presc),
    .h_total(sh.h_total), .pc(pc), .hpos(hpos), .hhalf(hhalf),
    .half_end(half_end)
  );

  rtg_vcount u_vcount (
    .clk(clk), .rst_n(rst_n), .half_end(half_end), .v_total(sh.v_total),
    .ilace_next(cfg_interlace), .vcnt(vcnt), .field_st(field_st),
    .frame_wrap(frame_wrap)
  );

  rtg_decode u_decode (
    .clk(clk), .rst_n(rst_n), .run(!init_q),
    .h_total(sh.h_total), .h_disp_on(sh.h_disp_on), .h_disp_off(sh.h_disp_off),
    .h_blank_on(sh.h_blank_on), .h_blank_off(sh.h_blank_off),
    .h_sync_on(sh.h_sync_on), .v_blank_on(sh.v_blank_on),
    .v_blank_off(sh.v_blank_off), .v_disp_on(sh.v_disp_on),
    .v_disp_off(sh.v_disp_off), .v_sync_on(sh.v_sync_on),
    .h_pol(sh.h_pol), .v_pol(sh.v_pol), .ilace(sh.ilace), .dbl(sh.dbl),
    .hpos(hpos), .hhalf(hhalf), .vcnt(vcnt), .field_st(field_st),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .disp_en(disp_en), .field(field), .line_repeat(line_repeat)
  );

  assert_field_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sh.ilace |-> !field_st);
  assert_frame_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (vcnt == '0 && hpos == '0 && pc == '0));
endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  import rtg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  rtg_cfg_t cur_cfg = '0;
  logic hsync, vsync, hblank, vblank, disp_en, field, line_repeat;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_h_total(cur_cfg.h_total), .cfg_h_disp_on(cur_cfg.h_disp_on),
    .cfg_h_disp_off(cur_cfg.h_disp_off), .cfg_h_blank_on(cur_cfg.h_blank_on),
    .cfg_h_blank_off(cur_cfg.h_blank_off), .cfg_h_sync_on(cur_cfg.h_sync_on),
    .cfg_v_total(cur_cfg.v_total), .cfg_v_blank_on(cur_cfg.v_blank_on),
    .cfg_v_blank_off(cur_cfg.v_blank_off), .cfg_v_disp_on(cur_cfg.v_disp_on),
    .cfg_v_disp_off(cur_cfg.v_disp_off), .cfg_v_sync_on(cur_cfg.v_sync_on),
    .cfg_h_pol(cur_cfg.h_pol), .cfg_v_pol(cur_cfg.v_pol),
    .cfg_presc(cur_cfg.presc), .cfg_interlace(cur_cfg.ilace),
    .cfg_double(cur_cfg.dbl),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .disp_en(disp_en), .field(field), .line_repeat(line_repeat)
  );

  int n_chk = 0;
  int n_fail = 0;
  int popped = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [6:0] exp_q[$];
  bit m_half = 1'b0;
  bit m_field = 1'b0;

  // bit order: hsync vsync hblank vblank disp_en field line_repeat
  string sig_nm[7] = '{"hsync", "vsync", "hblank", "vblank", "disp_en", "field", "line_repeat"};
  string sig_rq[7] = '{"R4,R7", "R5,R7", "R4", "R5", "R3,R6", "R8", "R9"};

  function automatic int line_pos(logic [HW:0] pt, int n);
    return pt[HW] ? n + int'(pt[HW-1:0]) : int'(pt[HW-1:0]);
  endfunction

  // expected pins for one counter state, built from the requirement text
  function automatic logic [6:0] model(rtg_cfg_t c, bit half, int v, int hp, bit fld);
    int n = int'(c.h_total) + 2;
    int p = half ? n + hp : hp;
    bit hde = (p >= line_pos(c.h_disp_on, n)) && (p < n + int'(c.h_disp_off));
    bit hbl = !((p >= line_pos(c.h_blank_off, n)) && (p < line_pos(c.h_blank_on, n)));
    bit hsy = (p >= line_pos(c.h_sync_on, n));
    bit vde = (v >= int'(c.v_disp_on)) && (v < int'(c.v_disp_off));
    bit vbl = !((v >= int'(c.v_blank_off)) && (v < int'(c.v_blank_on)));
    bit vsy = (v >= int'(c.v_sync_on));
    bit rep = c.dbl && !c.ilace && vde && (((v - int'(c.v_disp_on)) / 2) % 2 == 1);
    bit hpin = c.h_pol ? hsy : !hsy;
    bit vpin = c.v_pol ? vsy : !vsy;
    return {hpin, vpin, hbl, vbl, hde && vde, fld, rep};
  endfunction

  function automatic int frame_len(rtg_cfg_t c);
    int pr = (c.presc == 2'd0) ? 1 : (c.presc == 2'd1) ? 2 : 4;   // R2 pacing
    return (int'(c.v_total) + 1) * (int'(c.h_total) + 2) * pr;
  endfunction

  // driver: queue every clock of one frame; first frame follows reset (R10)
  task automatic push_frame(rtg_cfg_t c, bit first);
    int pr = (c.presc == 2'd0) ? 1 : (c.presc == 2'd1) ? 2 : 4;
    if (!first) m_field = c.ilace ? !m_field : 1'b0;   // R8
    for (int v = 0; v <= int'(c.v_total); v++) begin
      for (int hp = 0; hp < int'(c.h_total) + 2; hp++)
        for (int k = 0; k < pr; k++)
          exp_q.push_back(model(c, m_half, v, hp, m_field));
      m_half = !m_half;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pop and compare once per clock, away from the active edge
  initial begin
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        logic [6:0] a;
        bit bad;
        e = exp_q.pop_front();
        a = {hsync, vsync, hblank, vblank, disp_en, field, line_repeat};
        bad = 1'b0;
        for (int b = 0; b < 7; b++) begin
          if (a[6-b] !== e[6-b]) begin
            bad = 1'b1;
            $display("FAIL %s %s at item %0d: actual=%b expected=%b",
                     sig_rq[b], sig_nm[b], popped, a[6-b], e[6-b]);
          end
        end
        n_chk++;
        if (bad) n_fail++;
        popped++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual=timeout expected=run complete");
      finish_run();
    end
  end

  initial begin
    rtg_cfg_t ca, cb, cc;
    int la, lb;
    // A: progressive, divide 1, active-low syncs, first-half display start
    ca = '0;
    ca.h_total = 9'd10;  ca.h_disp_on = {1'b0, 9'd3}; ca.h_disp_off = 9'd8;
    ca.h_blank_on = {1'b1, 9'd9}; ca.h_blank_off = {1'b0, 9'd2};
    ca.h_sync_on = {1'b1, 9'd10};
    ca.v_total = 11'd19; ca.v_blank_off = 11'd3; ca.v_disp_on = 11'd3;
    ca.v_disp_off = 11'd15; ca.v_blank_on = 11'd15; ca.v_sync_on = 11'd17;
    ca.presc = 2'd0;
    // B: interlace (odd total), divide 2, active-high syncs, second-half
    // display start, doubling requested too (interlace wins, R9)
    cb = '0;
    cb.h_total = 9'd6;   cb.h_disp_on = {1'b1, 9'd1}; cb.h_disp_off = 9'd6;
    cb.h_blank_on = {1'b1, 9'd7}; cb.h_blank_off = {1'b1, 9'd0};
    cb.h_sync_on = {1'b1, 9'd7};
    cb.v_total = 11'd14; cb.v_blank_off = 11'd3; cb.v_disp_on = 11'd3;
    cb.v_disp_off = 11'd11; cb.v_blank_on = 11'd12; cb.v_sync_on = 11'd13;
    cb.h_pol = 1'b1; cb.v_pol = 1'b1; cb.presc = 2'd1;
    cb.ilace = 1'b1; cb.dbl = 1'b1;
    // C: line doubling, select 3 maps to divide 4 (R2)
    cc = '0;
    cc.h_total = 9'd2;   cc.h_disp_on = {1'b0, 9'd1}; cc.h_disp_off = 9'd1;
    cc.h_blank_on = {1'b1, 9'd2}; cc.h_blank_off = {1'b0, 9'd1};
    cc.h_sync_on = {1'b1, 9'd3};
    cc.v_total = 11'd11; cc.v_blank_off = 11'd1; cc.v_disp_on = 11'd1;
    cc.v_disp_off = 11'd9; cc.v_blank_on = 11'd10; cc.v_sync_on = 11'd10;
    cc.presc = 2'd3; cc.dbl = 1'b1;

    cur_cfg = ca;
    repeat (3) @(negedge clk);
    n_chk++;   // R1 reset state
    if ({hsync, vsync, hblank, vblank, disp_en, field, line_repeat} !== 7'b1100000) begin
      n_fail++;
      $display("FAIL R1 reset state: actual=%b expected=%b",
               {hsync, vsync, hblank, vblank, disp_en, field, line_repeat}, 7'b1100000);
    end

    la = frame_len(ca);
    lb = frame_len(cb);
    push_frame(ca, 1'b1);
    push_frame(ca, 1'b0);
    push_frame(cb, 1'b0);
    push_frame(cb, 1'b0);
    push_frame(cb, 1'b0);
    push_frame(cc, 1'b0);
    push_frame(cc, 1'b0);

    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);   // capture clock
    @(posedge clk);   // first counting clock, item 0 visible after it (R10)
    mon_on = 1'b1;

    // mid-frame changes must not show before the next wrap (R10)
    wait (popped >= la + la / 2);
    @(negedge clk);
    cur_cfg = cb;
    wait (popped >= 2 * la + 2 * lb + lb / 2);
    @(negedge clk);
    cur_cfg = cc;

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule